// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block runs an external 12-bit successive-approximation converter for a host. When the host asks for a sample, the sequencer pulls the converter's read/convert line low for a legal pulse width. It then decides when the conversion has finished, reads the result back and returns it with a single-cycle strobe. Every converter timing rule is given in nanoseconds and turned into clock cycles when the block is built.

Completion can be detected in two ways, chosen when a request is accepted. In status mode the sequencer synchronises the converter's busy/status line and waits for it to fall. It ignores that line during a blanking window after the convert pulse, and it gives up with an error strobe if the line never falls. In fixed-time mode it ignores status and waits out the worst-case conversion time. The result comes back either as one 12-bit word, or as two left-justified bytes on the upper eight data lines, which the block reassembles.

Top module: `adc_conv_seq`

## Requirements
- R1: An accepted request drives `adc_rc_o` low from the next cycle for exactly 30 cycles (300 ns at 100 MHz), then returns it high.
- R2: In status mode (`mode_poll_i`=1) completion is a falling edge of `adc_sts_i` after two synchroniser stages. A fall that occurs within 60 cycles of `adc_rc_o` falling is not accepted.
- R3: In fixed-time mode (`mode_poll_i`=0) `adc_sts_i` has no effect, and the first read starts exactly 3500 cycles after `adc_rc_o` falls. `done_o` follows 3525 cycles after it falls on the 12-bit path and 3550 cycles after it falls on the 8-bit path.
- R4: Each read holds `adc_oe_o` high with a constant `adc_a0_o` for 25 cycles and samples `adc_data_i` at the end of the last one. `adc_oe_o` is only high while `adc_rc_o` is high.
- R5: With `bus8_i`=0, a single read with `adc_a0_o`=0 returns `result_o` = `adc_data_i[11:0]`.
- R6: With `bus8_i`=1, a read with `adc_a0_o`=0 supplies `result_o[11:4]` from `adc_data_i[11:4]`. A second read with `adc_a0_o`=1 supplies `result_o[3:0]` from `adc_data_i[11:8]`. `adc_data_i[7:0]` of the second read is discarded.
- R7: `start_i` is ignored while `busy_o` is high. It starts no further convert pulse and produces no further result.
- R8: `done_o` is high for exactly one cycle per conversion. `result_o` changes only as `done_o` rises and then holds its value.
- R9: In status mode, if no accepted fall occurs within 7000 cycles of `adc_rc_o` falling, `err_o` pulses for one cycle, `done_o` stays low and the block returns to idle.
- R10: After reset `adc_rc_o`=1 and `adc_oe_o`, `adc_a0_o`, `busy_o`, `done_o`, `err_o` are 0, with `result_o`=0.
- R11: `mode_poll_i` and `bus8_i` are captured when a request is accepted. Changes while busy have no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host conversion request |
| mode_poll_i | input | 1 | 1: watch status, 0: fixed worst-case wait |
| bus8_i | input | 1 | 1: two-byte readout, 0: one 12-bit read |
| adc_rc_o | output | 1 | Read/convert line, low starts a conversion |
| adc_oe_o | output | 1 | Converter output enable during reads |
| adc_a0_o | output | 1 | Byte select, 0 = upper byte, 1 = low nibble |
| adc_sts_i | input | 1 | Converter status, high while converting |
| adc_data_i | input | 12 | Converter data lines |
| busy_o | output | 1 | A conversion or readout is in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | One-cycle status-timeout strobe |
| result_o | output | 12 | Assembled conversion result |

## Verification
In fixed-time mode every result has an exact due cycle, counted from the clock edge that accepts the request. On the 12-bit path it falls 3525 cycles later. On the byte path it falls 3550 cycles later. In status mode a fall of the status line after converter cycle N makes the result due within a six-cycle window starting at N+25 (12-bit) or N+50 (bytes). That window covers the two synchroniser stages and the edge detector. The status timeout is due exactly 7000 cycles after acceptance. The driver stores these windows with each expected value. The monitor compares the cycle counter at the strobe against them, sampling on the falling clock edge. The converter model presents valid data only after the enable has been steady for the access time, so a read sampled too early returns a wrong value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CONV,
      S_BLANK,
      S_WAIT,
      S_RD_HI,
      S_RD_LO,
      S_DONE,
      S_ERR
   } seq_state_t;

   // nanoseconds to clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int clk_mhz);
      return (ns * clk_mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_seq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int TW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_assemble.sv
module adc_seq_assemble #(
   parameter int DATA_W    = 12,
   parameter int BYTE_W    = 8,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_full_i,
   input  logic              cap_hi_i,
   input  logic              cap_lo_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int LOW_W = DATA_W - BYTE_W;

   logic [DATA_W-1:0] res_q;

   if (NARROW_EN) begin : g_narrow
      logic [BYTE_W-1:0] hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        hi_q <= '0;
         else if (cap_hi_i) hi_q <= data_i[DATA_W-1 -: BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          res_q <= '0;
         else if (cap_full_i) res_q <= data_i;
         else if (cap_lo_i)   res_q <= {hi_q, data_i[DATA_W-1 -: LOW_W]};
      end
   end else begin : g_wide_only
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          res_q <= '0;
         else if (cap_full_i) res_q <= data_i;
      end
   end

   assign result_o = res_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int CLK_MHZ        = 100,
   parameter int T_RC_LOW_NS    = 300,
   parameter int T_STS_BLANK_NS = 600,
   parameter int T_ACCESS_NS    = 250,
   parameter int T_CONV_MAX_NS  = 35000,
   parameter int DATA_W         = 12,
   parameter int BYTE_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit NARROW_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_poll_i,
   input  logic              bus8_i,
   output logic              adc_rc_o,
   output logic              adc_oe_o,
   output logic              adc_a0_o,
   input  logic              adc_sts_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] result_o
);

   localparam int LOW_CYC   = ns_to_cyc(T_RC_LOW_NS, CLK_MHZ);
   localparam int BLANK_CYC = ns_to_cyc(T_STS_BLANK_NS, CLK_MHZ);
   localparam int ACC_CYC   = ns_to_cyc(T_ACCESS_NS, CLK_MHZ);
   localparam int TMO_CYC   = ns_to_cyc(T_CONV_MAX_NS, CLK_MHZ);
   localparam int WDOG_CYC  = 2 * TMO_CYC;
   localparam int TW        = $clog2(WDOG_CYC + 1);

   if (LOW_CYC < 1 || ACC_CYC < 1) begin : g_bad_pulse
      $error("adc_conv_seq: pulse and access widths must be at least one cycle");
   end
   if (BLANK_CYC <= LOW_CYC || TMO_CYC <= BLANK_CYC) begin : g_bad_order
      $error("adc_conv_seq: need convert pulse < blanking < conversion time");
   end
   if (DATA_W <= BYTE_W || DATA_W > 2 * BYTE_W) begin : g_bad_width
      $error("adc_conv_seq: data must span more than one and at most two bytes");
   end

   seq_state_t    st_q, st_d;
   logic          poll_q, bus8_q;
   logic          ld;
   logic [TW-1:0] ld_val;
   logic          t_zero;
   logic          sts_s, sts_d_q, sts_fall;
   logic          cap_full, cap_hi, cap_lo;

   adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_sts_i),
      .q_o   (sts_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_d_q <= 1'b0;
      else        sts_d_q <= sts_s;
   end
   assign sts_fall = sts_d_q & ~sts_s;

   adc_seq_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (ld_val),
      .zero_o     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_q <= 1'b0;
         bus8_q <= 1'b0;
      end else if (st_q == S_IDLE && start_i) begin
         poll_q <= mode_poll_i;
         bus8_q <= bus8_i & NARROW_EN;
      end
   end

   always_comb begin
      st_d     = st_q;
      ld       = 1'b0;
      ld_val   = '0;
      cap_full = 1'b0;
      cap_hi   = 1'b0;
      cap_lo   = 1'b0;
      unique case (st_q)
         S_IDLE: if (start_i) begin
            st_d   = S_CONV;
            ld     = 1'b1;
            ld_val = TW'(LOW_CYC - 1);
         end
         S_CONV: if (t_zero) begin
            ld = 1'b1;
            if (poll_q) begin
               st_d   = S_BLANK;
               ld_val = TW'(BLANK_CYC - LOW_CYC - 1);
            end else begin
               st_d   = S_WAIT;
               ld_val = TW'(TMO_CYC - LOW_CYC - 1);
            end
         end
         S_BLANK: if (t_zero) begin
            st_d   = S_WAIT;
            ld     = 1'b1;
            ld_val = TW'(WDOG_CYC - BLANK_CYC - 1);
         end
         S_WAIT: begin
            if (poll_q ? sts_fall : t_zero) begin
               st_d   = S_RD_HI;
               ld     = 1'b1;
               ld_val = TW'(ACC_CYC - 1);
            end else if (t_zero) begin
               st_d = S_ERR;
            end
         end
         S_RD_HI: if (t_zero) begin
            if (bus8_q) begin
               cap_hi = 1'b1;
               st_d   = S_RD_LO;
               ld     = 1'b1;
               ld_val = TW'(ACC_CYC - 1);
            end else begin
               cap_full = 1'b1;
               st_d     = S_DONE;
            end
         end
         S_RD_LO: if (t_zero) begin
            cap_lo = 1'b1;
            st_d   = S_DONE;
         end
         S_DONE:  st_d = S_IDLE;
         S_ERR:   st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   adc_seq_assemble #(
      .DATA_W    (DATA_W),
      .BYTE_W    (BYTE_W),
      .NARROW_EN (NARROW_EN)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_full_i (cap_full),
      .cap_hi_i   (cap_hi),
      .cap_lo_i   (cap_lo),
      .data_i     (adc_data_i),
      .result_o   (result_o)
   );

   assign adc_rc_o = (st_q != S_CONV);
   assign adc_oe_o = (st_q == S_RD_HI) || (st_q == S_RD_LO);
   assign adc_a0_o = (st_q == S_RD_LO);
   assign busy_o   = (st_q != S_IDLE);
   assign done_o   = (st_q == S_DONE);
   assign err_o    = (st_q == S_ERR);

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int LOW_CYC = 30,
   parameter int DATA_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_rc_o,
   input logic              adc_oe_o,
   input logic              adc_a0_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [DATA_W-1:0] result_o
);

   int unsigned low_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_cnt_q <= 0;
      else if (!adc_rc_o) low_cnt_q <= low_cnt_q + 1;
      else                low_cnt_q <= 0;
   end

   p_rc_low_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_rc_o) |-> (low_cnt_q == LOW_CYC));

   p_oe_read_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_oe_o |-> adc_rc_o);

   p_a0_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_a0_o |-> adc_oe_o);

   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rc_o) |-> !$past(busy_o));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(done_o) |-> $stable(result_o));

   p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!done_o && busy_o));

   p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !busy_o);

endmodule

bind adc_conv_seq adc_seq_chk #(
   .LOW_CYC (LOW_CYC),
   .DATA_W  (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .adc_rc_o (adc_rc_o),
   .adc_oe_o (adc_oe_o),
   .adc_a0_o (adc_a0_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .err_o    (err_o),
   .result_o (result_o)
);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;

   localparam int LOW  = 30;
   localparam int ACC  = 25;
   localparam int TMO  = 3500;
   localparam int WDOG = 7000;

   localparam int K_NORMAL = 0;
   localparam int K_STUCK  = 1;
   localparam int K_EARLY  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        mode_poll_i = 1'b0;
   logic        bus8_i = 1'b0;
   logic        adc_rc_o, adc_oe_o, adc_a0_o;
   logic        adc_sts_i;
   logic [11:0] adc_data_i;
   logic        busy_o, done_o, err_o;
   logic [11:0] result_o;

   always #5 clk = ~clk;

   adc_conv_seq i_adc_conv_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mode_poll_i (mode_poll_i),
      .bus8_i      (bus8_i),
      .adc_rc_o    (adc_rc_o),
      .adc_oe_o    (adc_oe_o),
      .adc_a0_o    (adc_a0_o),
      .adc_sts_i   (adc_sts_i),
      .adc_data_i  (adc_data_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .result_o    (result_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- converter model ----------------
   int          m_kind = K_NORMAL;
   int          m_conv = 400;
   logic [11:0] m_val = '0;
   logic        m_b8 = 1'b0;
   int          mcnt = 0;
   logic        rc_q = 1'b1;
   int          ocnt = 0;
   logic        a0_q = 1'b0;

   always @(posedge clk) begin
      rc_q <= adc_rc_o;
      if (rc_q && !adc_rc_o) mcnt <= 1;
      else if (mcnt != 0)    mcnt <= mcnt + 1;
      a0_q <= adc_a0_o;
      if (!adc_oe_o)              ocnt <= 0;
      else if (adc_a0_o != a0_q)  ocnt <= 1;
      else                        ocnt <= ocnt + 1;
   end

   always_comb begin
      case (m_kind)
         K_STUCK: adc_sts_i = (mcnt >= 5);
         K_EARLY: adc_sts_i = (mcnt >= 2) && (mcnt < 20);
         default: adc_sts_i = (mcnt >= 5) && (mcnt < m_conv);
      endcase
   end

   always_comb begin
      if (adc_oe_o && adc_rc_o && ocnt >= ACC-1 && adc_a0_o == a0_q) begin
         if (!m_b8)          adc_data_i = m_val;
         else if (!adc_a0_o) adc_data_i = {m_val[11:4], 4'h5};
         else                adc_data_i = {m_val[3:0], 4'h9, 4'hA};
      end else begin
         adc_data_i = 12'h6C3;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [11:0] v;
      int          t0;
      int          lo;
      int          hi;
      string       req;
   } exp_t;

   exp_t sbq[$];
   int   done_cnt = 0;
   int   err_cnt = 0;
   int   err_cyc = 0;
   int   lw = 0;
   int   last_lw = 0;
   int   rc_falls = 0;
   logic done_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            done_cnt++;
            if (sbq.size() == 0) begin
               chk(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sbq.pop_front();
               chk(result_o == e.v, e.req, "result", int'(result_o), int'(e.v));
               chk((cyc - e.t0) >= e.lo && (cyc - e.t0) <= e.hi, e.req,
                   "done latency", cyc - e.t0, e.lo);
            end
            chk(!done_prev, "R8", "done wider than one cycle", 1, 0);
         end
         if (err_o) begin
            err_cnt++;
            err_cyc = cyc;
         end
         if (!adc_rc_o) begin
            if (lw == 0) rc_falls++;
            lw++;
         end else if (lw != 0) begin
            last_lw = lw;
            lw = 0;
         end
         done_prev = done_o;
      end
   end

   // ---------------- driver ----------------
   task automatic run(input logic [11:0] val, input bit poll, input bit b8,
                      input int kind, input int conv, input bit exp_err,
                      input bit extra_start, input string req);
      int d0, e0, f0, t0;
      exp_t e;
      d0 = done_cnt; e0 = err_cnt; f0 = rc_falls;
      m_val = val; m_b8 = b8; m_kind = kind; m_conv = conv;
      @(negedge clk);
      mode_poll_i = poll;
      bus8_i = b8;
      start_i = 1'b1;
      t0 = cyc + 1;
      if (!exp_err) begin
         e.v = val; e.t0 = t0; e.req = req;
         if (!poll) begin
            e.lo = TMO + ACC * (b8 ? 2 : 1);
            e.hi = e.lo;
         end else begin
            e.lo = conv + ACC * (b8 ? 2 : 1);
            e.hi = e.lo + 6;
         end
         sbq.push_back(e);
      end
      @(negedge clk);
      start_i = 1'b0;
      // R11: flip the mode inputs while busy; the captured ones must rule
      mode_poll_i = ~poll;
      bus8_i = ~b8;
      if (extra_start) begin
         repeat (100) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!busy_o, req, "busy cleared", int'(busy_o), 0);
      chk(last_lw == LOW, "R1", "convert pulse width", last_lw, LOW);
      chk(rc_falls - f0 == 1, "R7", "convert pulses per request", rc_falls - f0, 1);
      if (exp_err) begin
         chk(err_cnt - e0 == 1, "R9", "error strobes", err_cnt - e0, 1);
         chk(done_cnt == d0, "R9", "no done on error", done_cnt - d0, 0);
      end else begin
         chk(done_cnt - d0 == 1, req, "done strobes", done_cnt - d0, 1);
         chk(err_cnt == e0, req, "no error", err_cnt - e0, 0);
         chk(result_o == val, "R8", "result held after done", int'(result_o), int'(val));
      end
      if (exp_err && kind == K_STUCK)
         chk(err_cyc - t0 == WDOG, "R9", "error latency", err_cyc - t0, WDOG);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values
      chk(adc_rc_o == 1'b1, "R10", "rc in reset", int'(adc_rc_o), 1);
      chk(!adc_oe_o && !adc_a0_o, "R10", "oe/a0 in reset", int'({adc_oe_o, adc_a0_o}), 0);
      chk(!busy_o && !done_o && !err_o, "R10", "flags in reset",
          int'({busy_o, done_o, err_o}), 0);
      chk(result_o == 12'h000, "R10", "result in reset", int'(result_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy_o && adc_rc_o, "R10", "idle after reset", int'(busy_o), 0);

      // R3 + R5: fixed time, status stuck high must not matter
      run(12'hA5C, 1'b0, 1'b0, K_STUCK, 400, 1'b0, 1'b0, "R3");
      // R3 + R6: fixed time, byte readout
      run(12'h3E7, 1'b0, 1'b1, K_STUCK, 400, 1'b0, 1'b0, "R6");
      // R2 + R5: status mode, word readout
      run(12'h001, 1'b1, 1'b0, K_NORMAL, 400, 1'b0, 1'b0, "R2");
      // R2 + R6 + R4: status mode, byte readout, extremes
      run(12'hFFF, 1'b1, 1'b1, K_NORMAL, 700, 1'b0, 1'b0, "R6");
      run(12'h800, 1'b1, 1'b1, K_NORMAL, 250, 1'b0, 1'b0, "R4");
      // R7: a start while busy is ignored
      run(12'h5A3, 1'b1, 1'b0, K_NORMAL, 500, 1'b0, 1'b1, "R7");
      // R9: status never falls
      run(12'h123, 1'b1, 1'b0, K_STUCK, 400, 1'b1, 1'b0, "R9");
      chk(result_o == 12'h5A3, "R9", "result untouched by error", int'(result_o), 12'h5A3);
      // R2: fall inside blanking window is not completion
      run(12'h456, 1'b1, 1'b0, K_EARLY, 400, 1'b1, 1'b0, "R2");
      // R5 after error recovery, fixed time
      run(12'h7C1, 1'b0, 1'b0, K_NORMAL, 300, 1'b0, 1'b0, "R5");

      chk(sbq.size() == 0, "R8", "results outstanding", sbq.size(), 0);
      summary();
      $finish;
   end

endmodule